// File: doc/BRIEF.md
# Programmable Reload Interval Timer

This block is a single-channel 16-bit down-counting timer. Software programs a reload value and a control word through a small register port. A start, given by a control write or by a trigger pin, copies the reload value into the counter. The counter then decrements once per tick of the selected count clock. That count clock is either the system clock divided by 2, 8, 32, 64 or 128, or the rising edge of an external event input after it has been synchronised.

When the counter decrements past zero, an underflow occurs. In auto-reload mode the counter refills from the reload register, keeps running and toggles the timer output. In one-shot mode the counter stops, and the output marks the counting period instead. A polarity bit inverts the output in both modes. Each underflow sets a sticky flag, which raises the interrupt line when interrupts are enabled.

Top module: `ivtmr_top`

## Requirements
- R1: Counting takes (reload+1) ticks. For divider codes 000, 001, 010, 101 and 110 (field bits 8:6 of the control word), the tick period is 2, 8, 32, 64 and 128 system clocks. After a start registered at edge E0, the one-shot underflow lands on edge E0 + (reload+1)·divider. The counter holds the reload value right after the start.
- R2: With code 011, the counter decrements once per rising edge of the event input, after that input passes through a two-stage synchroniser. A pulse at least 2 system clocks long is always counted.
- R3: With code 100 or 111, a running counter keeps its value indefinitely.
- R4: In auto-reload mode (control bit 2 = 1), an underflow reloads the counter and counting continues. The timer output toggles on every underflow, and a start resets the toggle state to 0.
- R5: In one-shot mode (control bit 2 = 0), counting stops at the first underflow and the counter stays at 0. The output is active while counting.
- R6: Writing the enable bit (control bit 0) to 0 stops counting and freezes the counter. Writing it back to 1 without a trigger does not resume counting.
- R7: A start happens only when the enable bit is already 1, or when it is written to 1 in the same control write. The start comes from the sw_trig pin or from writing 1 to control bit 1, which always reads 0.
- R8: Control bit 3 inverts the timer output. The output is 0 when bit 3 is 0 and the toggle state is idle or the timer is stopped in one-shot mode.
- R9: An underflow sets the sticky flag (control bit 5). Writing 0 to bit 5 clears the flag and writing 1 leaves it unchanged. irq equals the flag AND the interrupt enable (control bit 4).
- R10: Register map on rd_addr/wr_addr: 0 is the control word, where bit 9 reads the running status; 1 is the reload value; 2 is the current count (read only). After reset, every register reads 0 and both irq and tmr_out are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 16 | Read data for rd_addr (combinational) |
| sw_trig | input | 1 | Start request, honoured only when enabled |
| ev_in | input | 1 | External event input (asynchronous) |
| irq | output | 1 | Underflow interrupt |
| tmr_out | output | 1 | Timer output pin |

## Verification
The hardest state to reach from the ports is a stopped timer whose enable bit has been set again. The bench reaches it with a disable write in the middle of a run, followed by a write that sets enable without a trigger. It then confirms that the count readback stays frozen and that the running bit stays low. The bench also sweeps every divider code against several reload values. For each pair, it counts the edges to the underflow and compares them with (reload+1)·divider. The reserved codes are held for hundreds of cycles to show that the count does not change.

// File: rtl/ivtmr_pkg.sv
package ivtmr_pkg;

  localparam int PRE_W = 7;

  localparam int B_EN    = 0;
  localparam int B_TRIG  = 1;
  localparam int B_MODE  = 2;
  localparam int B_INV   = 3;
  localparam int B_IEN   = 4;
  localparam int B_FLAG  = 5;
  localparam int B_SEL   = 6;
  localparam int B_RUN   = 9;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_RLD   = 2'd1;
  localparam logic [1:0] A_COUNT = 2'd2;

  typedef enum logic [2:0] {
    CS_DIV2   = 3'b000,
    CS_DIV8   = 3'b001,
    CS_DIV32  = 3'b010,
    CS_EVENT  = 3'b011,
    CS_RSV_A  = 3'b100,
    CS_DIV64  = 3'b101,
    CS_DIV128 = 3'b110,
    CS_RSV_B  = 3'b111
  } clk_sel_e;

  typedef struct packed {
    clk_sel_e sel;
    logic     flag;
    logic     ien;
    logic     inv;
    logic     mode;
    logic     en;
  } ctrl_t;

  function automatic logic [PRE_W-1:0] sel_mask(input clk_sel_e s);
    case (s)
      CS_DIV2:   return PRE_W'(1);
      CS_DIV8:   return PRE_W'(7);
      CS_DIV32:  return PRE_W'(31);
      CS_DIV64:  return PRE_W'(63);
      CS_DIV128: return PRE_W'(127);
      default:   return '0;
    endcase
  endfunction

  function automatic logic sel_is_div(input clk_sel_e s);
    return (s == CS_DIV2) || (s == CS_DIV8) || (s == CS_DIV32) ||
           (s == CS_DIV64) || (s == CS_DIV128);
  endfunction

  function automatic logic out_level(input logic mode, input logic running,
                                     input logic tgl, input logic inv);
    return mode ? (tgl ^ inv) : (running ^ inv);
  endfunction

endpackage

// File: rtl/ivtmr_regs.sv
module ivtmr_regs
  import ivtmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  input  logic             sw_trig,
  input  logic             uf_evt,
  input  logic             running,
  input  logic [CNT_W-1:0] count,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] rld,
  output logic             en_live,
  output logic             start_evt,
  output logic [CNT_W-1:0] rd_data
);

  logic wr_ctrl, wr_rld;

  assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign wr_rld    = wr_en && (wr_addr == A_RLD);
  assign en_live   = wr_ctrl ? wr_data[B_EN] : ctrl.en;
  assign start_evt = en_live && (sw_trig || (wr_ctrl && wr_data[B_TRIG]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      rld  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.en   <= wr_data[B_EN];
        ctrl.mode <= wr_data[B_MODE];
        ctrl.inv  <= wr_data[B_INV];
        ctrl.ien  <= wr_data[B_IEN];
        ctrl.sel  <= clk_sel_e'(wr_data[B_SEL+2:B_SEL]);
      end
      if (uf_evt)
        ctrl.flag <= 1'b1;
      else if (wr_ctrl && !wr_data[B_FLAG])
        ctrl.flag <= 1'b0;
      if (wr_rld)
        rld <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[B_EN]          = ctrl.en;
        rd_data[B_MODE]        = ctrl.mode;
        rd_data[B_INV]         = ctrl.inv;
        rd_data[B_IEN]         = ctrl.ien;
        rd_data[B_FLAG]        = ctrl.flag;
        rd_data[B_SEL+2:B_SEL] = ctrl.sel;
        rd_data[B_RUN]         = running;
      end
      A_RLD:   rd_data = rld;
      A_COUNT: rd_data = count;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/ivtmr_tick.sv
module ivtmr_tick
  import ivtmr_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_sel_e sel,
  input  logic     start_evt,
  input  logic     ev_in,
  output logic     tick
);

  localparam int SH_W = SYNC_N + 1;

  logic [PRE_W-1:0] pcnt;
  logic [SH_W-1:0]  ev_sh;
  logic             ev_rise;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcnt <= '0;
    else if (start_evt)
      pcnt <= '0;
    else
      pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ev_sh <= '0;
    else
      ev_sh <= {ev_sh[SH_W-2:0], ev_in};
  end

  assign ev_rise = ev_sh[SYNC_N-1] && !ev_sh[SYNC_N];
  assign mask    = sel_mask(sel);

  always_comb begin
    if (sel == CS_EVENT)
      tick = ev_rise;
    else if (sel_is_div(sel))
      tick = ((pcnt & mask) == mask);
    else
      tick = 1'b0;
  end

endmodule

// File: rtl/ivtmr_count.sv
module ivtmr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             tick,
  input  logic             en_live,
  input  logic             mode,
  input  logic [CNT_W-1:0] rld,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             tgl,
  output logic             uf_evt
);

  logic step;

  assign step   = running && tick && en_live;
  assign uf_evt = step && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
      tgl     <= 1'b0;
    end else if (start_evt) begin
      count   <= rld;
      running <= 1'b1;
      tgl     <= 1'b0;
    end else if (!en_live) begin
      running <= 1'b0;
    end else if (step) begin
      if (count == '0) begin
        if (mode) begin
          count <= rld;
          tgl   <= ~tgl;
        end else begin
          running <= 1'b0;
        end
      end else begin
        count <= count - 1'b1;
      end
    end
  end

endmodule

// File: rtl/ivtmr_top.sv
module ivtmr_top
  import ivtmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             sw_trig,
  input  logic             ev_in,
  output logic             irq,
  output logic             tmr_out
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] rld;
  logic [CNT_W-1:0] count;
  logic             en_live;
  logic             start_evt;
  logic             tick;
  logic             uf_evt;
  logic             running;
  logic             tgl;

  ivtmr_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .sw_trig(sw_trig),
    .uf_evt(uf_evt), .running(running), .count(count), .ctrl(ctrl),
    .rld(rld), .en_live(en_live), .start_evt(start_evt), .rd_data(rd_data)
  );

  ivtmr_tick #(.SYNC_N(SYNC_N)) tick_i (
    .clk(clk), .rst_n(rst_n), .sel(ctrl.sel), .start_evt(start_evt),
    .ev_in(ev_in), .tick(tick)
  );

  ivtmr_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .tick(tick),
    .en_live(en_live), .mode(ctrl.mode), .rld(rld), .count(count),
    .running(running), .tgl(tgl), .uf_evt(uf_evt)
  );

  assign irq     = ctrl.flag && ctrl.ien;
  assign tmr_out = out_level(ctrl.mode, running, tgl, ctrl.inv);

endmodule

// File: rtl/ivtmr_chk.sv
module ivtmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_evt,
  input logic             tick,
  input logic             uf_evt,
  input logic             en_live,
  input logic             en_q,
  input logic             mode_q,
  input logic [2:0]       sel_q,
  input logic             flag_q,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] rld
);

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (count == $past(rld)));

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && en_live && (count != '0) && !start_evt)
      |=> (count == $past(count) - 1'b1));

  p_hold_rsv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && ((sel_q == 3'b100) || (sel_q == 3'b111)) && !start_evt)
      |=> $stable(count));

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_evt && mode_q && !start_evt) |=> (running && (count == $past(rld))));

  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_evt && !mode_q && !start_evt) |=> !running);

  p_run_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> en_q);

  p_rise_by_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(start_evt));

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> flag_q);

endmodule

bind ivtmr_top ivtmr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .tick(tick),
  .uf_evt(uf_evt), .en_live(en_live), .en_q(ctrl.en), .mode_q(ctrl.mode),
  .sel_q(ctrl.sel), .flag_q(ctrl.flag), .running(running), .count(count),
  .rld(rld)
);

// File: tb/ivtmr_top_tb_top.sv
module ivtmr_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic        sw_trig = 1'b0;
  logic        ev_in = 1'b0;
  logic        irq;
  logic        tmr_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ivtmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sw_trig(sw_trig), .ev_in(ev_in), .irq(irq), .tmr_out(tmr_out)
  );

  function automatic logic [15:0] cw(input bit en, input bit trig, input bit mode,
                                     input bit inv, input bit ien, input bit flag,
                                     input logic [2:0] sel);
    logic [15:0] w;
    w = '0;
    w[0] = en; w[1] = trig; w[2] = mode; w[3] = inv; w[4] = ien; w[5] = flag;
    w[8:6] = sel;
    return w;
  endfunction

  function automatic int divider(input logic [2:0] code);
    case (code)
      3'b000: return 2;
      3'b001: return 8;
      3'b010: return 32;
      3'b101: return 64;
      default: return 128;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    sw_trig = 1'b1;
    @(negedge clk);
    sw_trig = 1'b0;
  endtask

  task automatic ev_pulse();
    @(negedge clk); ev_in = 1'b1;
    repeat (2) @(negedge clk);
    ev_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c1, c2;
    int n, tg;
    logic prev;
    int rl[3] = '{0, 1, 3};
    logic [2:0] codes[5] = '{3'b000, 3'b001, 3'b010, 3'b101, 3'b110};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(2'd0, v); check(v == 16'd0, "R10 ctrl reset", v, 0);
    rd(2'd1, v); check(v == 16'd0, "R10 reload reset", v, 0);
    rd(2'd2, v); check(v == 16'd0, "R10 count reset", v, 0);
    check(irq == 1'b0 && tmr_out == 1'b0, "R10 outputs reset", {irq, tmr_out}, 0);

    // R1 / R5 / R8 divider sweep in one-shot mode
    for (int ci = 0; ci < 5; ci++) begin
      for (int ri = 0; ri < 3; ri++) begin
        bit inv;
        int expn;
        inv = ((ci + ri) % 2) == 1;
        expn = (rl[ri] + 1) * divider(codes[ci]);
        wr(2'd1, 16'(rl[ri]));
        rd(2'd1, v); check(v == 16'(rl[ri]), "R10 reload readback", v, rl[ri]);
        wr(2'd0, cw(1, 1, 0, inv, 0, 0, codes[ci]));
        rd(2'd2, v); check(v == 16'(rl[ri]), "R1 load on start", v, rl[ri]);
        check(tmr_out == !inv, "R5 R8 active while counting", tmr_out, !inv);
        rd(2'd0, v);
        check(v[1] == 1'b0, "R7 trigger bit reads 0", v[1], 0);
        n = 0;
        while (n < 1000) begin
          @(negedge clk);
          n++;
          rd(2'd0, v);
          if (!v[9]) break;
        end
        check(n == expn, "R1 interval", n, expn);
        check(v[5] == 1'b1, "R9 flag set", v[5], 1);
        rd(2'd2, v); check(v == 16'd0, "R5 count stays 0", v, 0);
        check(tmr_out == inv, "R8 idle level", tmr_out, inv);
      end
    end

    // R9 sticky flag and irq
    check(irq == 1'b0, "R9 irq masked", irq, 0);
    wr(2'd0, cw(0, 0, 0, 0, 1, 1, 3'b000));
    rd(2'd0, v); check(v[5] == 1'b1, "R9 write 1 keeps flag", v[5], 1);
    check(irq == 1'b1, "R9 irq asserted", irq, 1);
    wr(2'd0, cw(0, 0, 0, 0, 1, 0, 3'b000));
    rd(2'd0, v); check(v[5] == 1'b0, "R9 write 0 clears flag", v[5], 0);
    check(irq == 1'b0, "R9 irq cleared", irq, 0);

    // R4 / R8 auto-reload toggling, period (2+1)*2 = 6
    for (int inv = 0; inv < 2; inv++) begin
      wr(2'd1, 16'd2);
      wr(2'd0, cw(1, 1, 1, inv[0], 0, 0, 3'b000));
      check(tmr_out == inv[0], "R4 R8 toggle cleared on start", tmr_out, inv);
      prev = tmr_out; tg = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (tmr_out != prev) tg++;
        prev = tmr_out;
      end
      check(tg == 10, "R4 toggle count", tg, 10);
      rd(2'd0, v); check(v[9] == 1'b1, "R4 keeps running", v[9], 1);
      check(tmr_out == inv[0], "R8 level after even toggles", tmr_out, inv);
    end

    // R6 disable freezes, re-enable does not resume
    wr(2'd1, 16'd100);
    wr(2'd0, cw(1, 1, 1, 0, 0, 0, 3'b000));
    repeat (20) @(negedge clk);
    wr(2'd0, cw(0, 0, 1, 0, 0, 0, 3'b000));
    rd(2'd0, v); check(v[9] == 1'b0, "R6 stopped by disable", v[9], 0);
    rd(2'd2, c1);
    repeat (20) @(negedge clk);
    rd(2'd2, c2); check(c2 == c1, "R6 count frozen", c2, c1);
    wr(2'd0, cw(1, 0, 1, 0, 0, 0, 3'b000));
    repeat (20) @(negedge clk);
    rd(2'd0, v); check(v[9] == 1'b0, "R6 re-enable no resume", v[9], 0);
    rd(2'd2, c2); check(c2 == c1, "R6 count still frozen", c2, c1);

    // R7 trigger qualification
    wr(2'd0, cw(0, 0, 1, 0, 0, 0, 3'b000));
    pulse_trig();
    rd(2'd0, v); check(v[9] == 1'b0, "R7 pin trigger while disabled", v[9], 0);
    wr(2'd0, cw(0, 1, 1, 0, 0, 0, 3'b000));
    rd(2'd0, v); check(v[9] == 1'b0, "R7 write trigger without enable", v[9], 0);
    rd(2'd2, v); check(v == c1, "R7 count untouched", v, c1);
    wr(2'd0, cw(1, 0, 1, 0, 0, 0, 3'b000));
    pulse_trig();
    rd(2'd0, v); check(v[9] == 1'b1, "R7 pin trigger when enabled", v[9], 1);
    rd(2'd2, v); check(v == 16'd100, "R7 load on pin trigger", v, 100);

    // R3 reserved codes hold
    for (int q = 0; q < 2; q++) begin
      logic [2:0] rc;
      rc = (q == 0) ? 3'b100 : 3'b111;
      wr(2'd1, 16'd5);
      wr(2'd0, cw(1, 1, 0, 0, 0, 0, rc));
      repeat (300) @(negedge clk);
      rd(2'd2, v); check(v == 16'd5, "R3 reserved code holds count", v, 5);
      rd(2'd0, v); check(v[9] == 1'b1, "R3 still running", v[9], 1);
    end

    // R2 external events, reload 2 -> underflow on third rising edge
    wr(2'd1, 16'd2);
    wr(2'd0, cw(1, 1, 0, 0, 0, 0, 3'b011));
    repeat (10) @(negedge clk);
    rd(2'd2, v); check(v == 16'd2, "R2 no tick without events", v, 2);
    ev_pulse();
    rd(2'd2, v); check(v == 16'd1, "R2 first event", v, 1);
    ev_pulse();
    rd(2'd2, v); check(v == 16'd0, "R2 second event", v, 0);
    rd(2'd0, v); check(v[9] == 1'b1, "R2 running before third", v[9], 1);
    ev_pulse();
    rd(2'd0, v); check(v[9] == 1'b0, "R2 underflow on third event", v[9], 0);
    check(v[5] == 1'b1, "R2 R9 flag after event underflow", v[5], 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule